// File: doc/BRIEF.md
# Privileged Status Register Write Unit

This block owns the 32-bit privileged status register of a processor core and applies software writes to it. A write carries data and a per-bit writable mask; bits outside the mask keep their stored value. When the core runs under the revision-6 rules, the write is filtered further. The three address-space enable bits form a dependency chain. The privilege-mode field refuses the value 3 when supervisor mode exists. The soft-reset and non-maskable-interrupt flags can only be cleared by software.

When a write takes away any address-space enable bit that was set, the block raises a one-cycle request to flush address translations. When the multithreading option is active, every write also mirrors the coprocessor-usable bits, the MX bit, the mode field and the current address-space ID into a per-thread status register. Deriving processor mode flags from the status value is done elsewhere.

Top module: `psr_write_unit`

## Requirements
- R1: A synchronous active-high reset loads the status register with the parameter RST_VAL (default 32'h001000E0), clears the thread-status register and holds the flush request low.
- R2: With rev6 low, a write sets each status bit whose wr_mask bit is 1 to the written bit and leaves every other bit unchanged, including a mode field value of 3.
- R3: Without a write strobe the status register keeps its value and no flush request is raised.
- R4: With rev6 high, the written data is adjusted before masking. A 0 in kernel enable bit 7 forces supervisor enable bit 6 to 0. A resulting 0 in bit 6 forces user enable bit 5 to 0.
- R5: With rev6 high, sup_ok high, wr_mask[4:3] = 2'b11 and written bits 4:3 = 2'b11, the mode field at bits 4:3 keeps its old value. In every other case the mode field follows R2.
- R6: With rev6 high, a written 1 in soft-reset bit 20 or NMI bit 19 leaves that bit unchanged, and a written 0 under the mask clears it.
- R7: flush_req is high for exactly the cycle after a write edge in which any of status bits 7:5 changed from 1 to 0, and low otherwise.
- R8: With mt_en high, a write sets thread bits 31:28 from status bits 31:28, thread bit 27 from status bit 24, thread bits 10:9 from status bits 4:3, and thread bits 7:0 from cur_asid. The status values used are the ones after the write. All other thread bits keep their values.
- R9: With mt_en low, a write leaves the thread-status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Value written to the status register |
| wr_mask | input | 32 | Writable-bit mask |
| rev6 | input | 1 | Apply revision-6 write filtering |
| sup_ok | input | 1 | Supervisor mode implemented |
| mt_en | input | 1 | Multithreading option active |
| cur_asid | input | 8 | Current address-space ID |
| status_q | output | 32 | Status register value |
| thread_q | output | 32 | Thread-status register value |
| flush_req | output | 1 | One-cycle translation flush request |

## Verification
Both registers are ports, so any wrong filtered bit shows on status_q, or on the mirrored fields of thread_q, in the cycle right after the write edge. A lost or spurious revocation shows as a missing or extra flush_req pulse in that same cycle. A state that should have been held by a rejected mode value or a clear-only flag shows up at once as a changed bit. The bench therefore compares all three outputs after every cycle it drives, idle cycles included.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W  = 32;
  localparam int unsigned ASID_W = 8;

  // status bit positions
  localparam int unsigned B_UX   = 5;
  localparam int unsigned B_SX   = 6;
  localparam int unsigned B_KX   = 7;
  localparam int unsigned B_MODE = 3;
  localparam int unsigned B_NMI  = 19;
  localparam int unsigned B_SRST = 20;
  localparam int unsigned B_MX   = 24;
  localparam int unsigned B_CU   = 28;

  // thread-status bit positions
  localparam int unsigned T_ASID = 0;
  localparam int unsigned T_MODE = 9;
  localparam int unsigned T_MX   = 27;
  localparam int unsigned T_CU   = 28;

  typedef logic [PSR_W-1:0]  psr_word_t;
  typedef logic [ASID_W-1:0] asid_t;

  // enable chain: kernel gates supervisor, supervisor gates user
  function automatic psr_word_t chain_fix(psr_word_t v);
    psr_word_t o;
    logic k, s, u;
    k = v[B_KX];
    s = v[B_SX] & k;
    u = v[B_UX] & s;
    o = v;
    o[B_KX] = k;
    o[B_SX] = s;
    o[B_UX] = u;
    return o;
  endfunction

  // revision-6 mask restrictions
  function automatic psr_word_t r6_mask(psr_word_t m, psr_word_t v, logic sup);
    psr_word_t o;
    o = m;
    if (sup && (m[B_MODE +: 2] == 2'b11) && (v[B_MODE +: 2] == 2'b11))
      o[B_MODE +: 2] = 2'b00;
    if (v[B_SRST]) o[B_SRST] = 1'b0;
    if (v[B_NMI])  o[B_NMI]  = 1'b0;
    return o;
  endfunction

  function automatic psr_word_t merge(psr_word_t old, psr_word_t v, psr_word_t m);
    return (old & ~m) | (v & m);
  endfunction

  function automatic logic [2:0] revoked(psr_word_t old, psr_word_t nw);
    return old[B_KX:B_UX] & ~nw[B_KX:B_UX];
  endfunction

  function automatic psr_word_t thread_sel_mask();
    psr_word_t m;
    m = '0;
    m[T_CU +: 4]       = 4'hF;
    m[T_MX]            = 1'b1;
    m[T_MODE +: 2]     = 2'b11;
    m[T_ASID +: ASID_W] = '1;
    return m;
  endfunction

  function automatic psr_word_t thread_fields(psr_word_t st, asid_t asid);
    psr_word_t t;
    t = '0;
    t[T_CU +: 4]        = st[B_CU +: 4];
    t[T_MX]             = st[B_MX];
    t[T_MODE +: 2]      = st[B_MODE +: 2];
    t[T_ASID +: ASID_W] = asid;
    return t;
  endfunction
endpackage

// File: rtl/psr_write_filter.sv
module psr_write_filter
  import psr_pkg::*;
(
  input  psr_word_t  old_st,
  input  psr_word_t  wr_data,
  input  psr_word_t  wr_mask,
  input  logic       rev6,
  input  logic       sup_ok,
  output psr_word_t  next_st,
  output logic [2:0] revoke
);
  psr_word_t data_fixed;
  psr_word_t mask_eff;

  always_comb begin
    if (rev6) begin
      data_fixed = chain_fix(wr_data);
      mask_eff   = r6_mask(wr_mask, wr_data, sup_ok);
    end else begin
      data_fixed = wr_data;
      mask_eff   = wr_mask;
    end
  end

  assign next_st = merge(old_st, data_fixed, mask_eff);
  assign revoke  = revoked(old_st, next_st);
endmodule

// File: rtl/psr_flush_gen.sv
module psr_flush_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] revoke,
  output logic       flush_req
);
  logic revoke_any;
  assign revoke_any = |revoke;

  always_ff @(posedge clk) begin
    if (rst) flush_req <= 1'b0;
    else     flush_req <= wr_en & revoke_any;
  end

  // R7: a pulse only follows a write
  a_r7_after_write: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(wr_en));
endmodule

// File: rtl/psr_thread_mirror.sv
module psr_thread_mirror
  import psr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic      mt_en,
  input  psr_word_t st_new,
  input  asid_t     cur_asid,
  output psr_word_t thread_q
);
  psr_word_t sel_mask;
  psr_word_t fields;
  logic      mirror_fire;

  assign sel_mask    = thread_sel_mask();
  assign fields      = thread_fields(st_new, cur_asid);
  assign mirror_fire = wr_en & mt_en;

  always_ff @(posedge clk) begin
    if (rst)              thread_q <= '0;
    else if (mirror_fire) thread_q <= (thread_q & ~sel_mask) | fields;
  end

  a_r8_asid_copy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mt_en) |=> thread_q[T_ASID +: ASID_W] == $past(cur_asid));

  a_r9_no_mirror: assert property (@(posedge clk) disable iff (rst)
    !mt_en |=> $stable(thread_q));
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h001000E0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [31:0] wr_mask,
  input  logic        rev6,
  input  logic        sup_ok,
  input  logic        mt_en,
  input  logic [7:0]  cur_asid,
  output logic [31:0] status_q,
  output logic [31:0] thread_q,
  output logic        flush_req
);
  psr_word_t  next_st;
  logic [2:0] revoke;

  psr_write_filter u_filter (
    .old_st (status_q),
    .wr_data(wr_data),
    .wr_mask(wr_mask),
    .rev6   (rev6),
    .sup_ok (sup_ok),
    .next_st(next_st),
    .revoke (revoke)
  );

  always_ff @(posedge clk) begin
    if (rst)        status_q <= RST_VAL;
    else if (wr_en) status_q <= next_st;
  end

  psr_flush_gen u_flush (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .revoke   (revoke),
    .flush_req(flush_req)
  );

  psr_thread_mirror u_mirror (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .mt_en   (mt_en),
    .st_new  (next_st),
    .cur_asid(cur_asid),
    .thread_q(thread_q)
  );

  a_r2_plain_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rev6) |=> status_q ==
      (($past(status_q) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(status_q) && !flush_req));

  a_r4_chain: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rev6 && (wr_mask[7:5] == 3'b111)) |=>
      ((!status_q[6] || status_q[7]) && (!status_q[5] || status_q[6])));

  a_r5_mode_reject: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rev6 && sup_ok && (wr_mask[4:3] == 2'b11) && (wr_data[4:3] == 2'b11))
      |=> status_q[4:3] == $past(status_q[4:3]));

  a_r6_clear_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rev6) |=> (!$rose(status_q[20]) && !$rose(status_q[19])));

  a_r7_flush_cause: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (($past(status_q[7:5]) & ~status_q[7:5]) != 3'b000));
endmodule

// File: tb/psr_write_unit_test.sv
`timescale 1ns/1ps
module psr_write_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data, wr_mask;
  logic        rev6, sup_ok, mt_en;
  logic [7:0]  cur_asid;
  logic [31:0] status_q, thread_q;
  logic        flush_req;

  always #2 clk = ~clk;

  psr_write_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .rev6(rev6), .sup_ok(sup_ok), .mt_en(mt_en), .cur_asid(cur_asid),
    .status_q(status_q), .thread_q(thread_q), .flush_req(flush_req)
  );

  typedef struct {
    logic [31:0] st;
    logic [31:0] th;
    logic        fl;
    string       tag;
  } item_t;

  item_t       q[$];
  int          total = 0;
  int          bad = 0;
  logic [31:0] m_st, m_th;
  bit          done = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // bench model: per-bit selection
  function automatic logic [31:0] model_status(logic [31:0] old, logic [31:0] d,
      logic [31:0] m, logic r6, logic sup);
    logic [31:0] r;
    logic k, s, u, take, val;
    k = d[7];
    s = k && d[6];
    u = s && d[5];
    for (int i = 0; i < 32; i++) begin
      take = m[i];
      val  = d[i];
      if (r6) begin
        if (i == 7) val = k;
        if (i == 6) val = s;
        if (i == 5) val = u;
        if ((i == 19 || i == 20) && d[i]) take = 1'b0;
        if ((i == 3 || i == 4) && sup && m[3] && m[4] && d[3] && d[4]) take = 1'b0;
      end
      r[i] = take ? val : old[i];
    end
    return r;
  endfunction

  task automatic op(bit we, logic [31:0] d, logic [31:0] m, bit r6, bit sup,
                    bit mt, logic [7:0] asid, string tag);
    item_t it;
    logic [31:0] ns;
    @(negedge clk);
    wr_en = we; wr_data = d; wr_mask = m; rev6 = r6; sup_ok = sup;
    mt_en = mt; cur_asid = asid;
    ns = we ? model_status(m_st, d, m, r6, sup) : m_st;
    it.fl = we && (((m_st[7] && !ns[7]) || (m_st[6] && !ns[6]) || (m_st[5] && !ns[5])));
    if (we && mt) begin
      m_th[31:28] = ns[31:28];
      m_th[27]    = ns[24];
      m_th[10:9]  = ns[4:3];
      m_th[7:0]   = asid;
    end
    m_st   = ns;
    it.st  = m_st;
    it.th  = m_th;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, "status", status_q, it.st);
      check(it.tag, "thread", thread_q, it.th);
      check(it.tag, "flush", {31'b0, flush_req}, {31'b0, it.fl});
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_data = 0; wr_mask = 0;
    rev6 = 0; sup_ok = 0; mt_en = 0; cur_asid = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "status", status_q, 32'h001000E0);
    check("R1", "thread", thread_q, 32'h0);
    check("R1", "flush", {31'b0, flush_req}, 32'h0);
    m_st = 32'h001000E0;
    m_th = 32'h0;
    rst = 1'b0;

    op(1, 32'hFFFF_FFFF, 32'h0000_FF00, 0, 0, 0, 8'h00, "R2 partial mask");
    op(1, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 0, 8'h00, "R2/R7 clear all flush");
    op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 8'h00, "R3 idle hold");
    op(1, 32'h0000_00F8, 32'hFFFF_FFFF, 0, 1, 0, 8'h00, "R2/R5 mode 3 accepted without rev6");
    op(1, 32'h0000_0060, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R4/R7 kernel off chain");
    op(1, 32'h0000_00C0, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R4 kernel+sup");
    op(1, 32'h0000_00A0, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R4/R7 sup off clears user");
    op(1, 32'h0000_0098, 32'hFFFF_FFFF, 1, 1, 0, 8'h00, "R5 mode 3 rejected");
    op(1, 32'h0000_0088, 32'hFFFF_FFFF, 1, 1, 0, 8'h00, "R5 mode 1 accepted");
    op(1, 32'h0000_0098, 32'hFFFF_FFFF, 1, 1, 0, 8'h00, "R5 mode 3 rejected keeps 1");
    op(1, 32'h0000_0098, 32'hFFFF_FFEF, 1, 1, 0, 8'h00, "R5 partial mode mask");
    op(1, 32'h0000_0098, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R5 no supervisor accepts 3");
    op(1, 32'h0018_00E0, 32'hFFFF_FFFF, 0, 0, 0, 8'h00, "R2 set nmi srst");
    op(1, 32'h0018_00E0, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R6 write one no effect");
    op(1, 32'h0000_00E0, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R6 clear");
    op(1, 32'h0018_00E0, 32'hFFFF_FFFF, 1, 0, 0, 8'h00, "R6 cannot set");
    op(1, 32'h0000_0000, 32'h0000_0080, 1, 0, 0, 8'h00, "R4/R7 partial mask chain");
    op(1, 32'hF100_00F8, 32'hFFFF_FFFF, 0, 0, 1, 8'h5A, "R8 mirror fields");
    op(1, 32'h5000_0088, 32'hFFFF_FFFF, 0, 0, 1, 8'hC3, "R8 mirror second");
    op(1, 32'hA100_0090, 32'hFFFF_FFFF, 0, 0, 0, 8'h11, "R9 no mirror");
    op(0, 32'h0, 32'h0, 0, 0, 1, 8'h77, "R3/R9 idle with mt");
    op(0, 32'h0, 32'h0, 0, 0, 0, 8'h00, "R3 idle");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule